// File: doc/BRIEF.md
# Microcode Sequencer With Conditional Branches

This block is the program counter and control engine of a small coprocessor. The host first writes 32-bit instruction words into the local microcode store. It then supplies the address of the first word and the length of the program, and pulses `hostStart`. The sequencer fetches one word at a time. Each instruction meant for an execution unit goes out on an issue strobe, and the sequencer holds until that unit reports completion. The sequencer resolves conditional branches itself, against the operand-A value that the register file returns for the source field of the current word.

A job ends in one of three ways. A finish opcode ends it cleanly. An undefined opcode ends it with an error. A fetch that falls outside the window set by start address and length also ends it with an error. In every case the sequencer goes idle and raises a level interrupt that stays high until the host acknowledges it. The error flags persist until the next job is started.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is held and directly after it, `busy`, `irq`, `errUndef`, `errOverrun` and `issueValid` are all low.
- R2: A `hostStart` pulse while idle latches `progStart` and `progLen` and begins fetching at `progStart`. Instruction words use these fields: opcode in bits [4:0], destination in [9:5], source A in [14:10], source B in [19:15], and the branch immediate in [29:20]. An opcode below 23 other than 8, 9, 10, 13 and 14 is sent out as the whole word on `issueInstr`, with `issueValid` high for exactly one cycle. The next word is not fetched until `unitDone` has been seen after the issue.
- R3: A taken branch loads PC with PC + immediate + 1, and a branch that is not taken loads PC + 1. Both sums wrap modulo 1024, so an immediate of 1022 steps back by one word.
- R4: Opcode 8 is taken when operand bits [31:0] are non-zero. Opcode 9 is taken when bits [31:0] are zero, opcode 13 when bits [3:0] are zero, and opcode 14 when bits [4:0] are zero.
- R5: `regAddrA` carries the source-A field of the instruction being executed, and the branch condition is taken from `opA`.
- R6: Opcode 10 ends the job. `busy` drops and `irq` rises with both error flags low, and nothing is issued.
- R7: An opcode of 23 or above ends the job with `irq` and `errUndef` set, and nothing is issued.
- R8: Before each fetch, (PC − start) mod 1024 is compared with the latched length. If it is not smaller, the job ends with `irq` and `errOverrun` set. A length of 0 therefore ends the job with no fetch at all.
- R9: `irq` stays high until a `hostAck` pulse, and the acknowledge leaves the error flags unchanged. A new start clears `irq` and both error flags.
- R10: A `hostStart` that arrives while `busy` is high has no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostStart | input | 1 | Start pulse from the host |
| hostAck | input | 1 | Interrupt acknowledge pulse |
| progStart | input | 10 | Address of the first program word |
| progLen | input | 11 | Program length in words (0 to 1024) |
| ramWrEn | input | 1 | Microcode store write enable |
| ramWrAddr | input | 10 | Microcode store write address |
| ramWrData | input | 32 | Microcode store write data |
| opA | input | 32 | Register value addressed by `regAddrA` |
| regAddrA | output | 5 | Source-A register address of the current word |
| issueValid | output | 1 | One-cycle strobe that sends a word to a unit |
| issueInstr | output | 32 | Current instruction word |
| unitDone | input | 1 | Completion strobe from the execution unit |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Sticky job-end interrupt |
| errUndef | output | 1 | Job ended on an undefined opcode |
| errOverrun | output | 1 | Job ended by leaving the program window |

## Verification
On every cycle the assertions check the following: the issue strobe lasts a single cycle; every fetch address lies inside the window; the interrupt holds until it is acknowledged or a new job starts; the two error flags never appear together; an overrun always comes with the interrupt; and a start that arrives while busy leaves the latched window untouched. Only the bench scenarios can show that whole programs run correctly. They compare the exact sequence of issued words and the way each job ends against a reference interpreter. That covers each branch flavour on operand values that separate the 4-, 5- and 32-bit tests, backward branches that wrap the PC, windows that cross address 1023, and zero-length jobs.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OP_BRNZ32 = 5'd8;
  localparam logic [OPC_W-1:0] OP_BRZ32  = 5'd9;
  localparam logic [OPC_W-1:0] OP_FIN    = 5'd10;
  localparam logic [OPC_W-1:0] OP_BRZ4   = 5'd13;
  localparam logic [OPC_W-1:0] OP_BRZ5   = 5'd14;
  localparam logic [OPC_W-1:0] OP_LIMIT  = 5'd23;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic loadJob;
    logic fetch;
    logic stepPc;
    logic branchPc;
    logic raiseIrq;
    logic flagUndef;
    logic flagOverrun;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ram.sv
module useq_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostStart,
  input  logic             unitDone,
  input  logic             inWindow,
  input  logic [OPC_W-1:0] opc,
  output seqStrobe_t       stb,
  output logic             issueValid,
  output logic             busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb        = '0;
    issueValid = 1'b0;
    stateNext  = state;
    case (state)
      ST_IDLE: begin
        if (hostStart) begin
          stb.loadJob = 1'b1;
          stateNext   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (inWindow) begin
          stb.fetch = 1'b1;
          stateNext = ST_EXEC;
        end else begin
          stb.raiseIrq    = 1'b1;
          stb.flagOverrun = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      ST_EXEC: begin
        if (opc == OP_BRNZ32 || opc == OP_BRZ32 || opc == OP_BRZ4 || opc == OP_BRZ5) begin
          stb.branchPc = 1'b1;
          stateNext    = ST_FETCH;
        end else if (opc == OP_FIN) begin
          stb.raiseIrq = 1'b1;
          stateNext    = ST_IDLE;
        end else if (opc >= OP_LIMIT) begin
          stb.raiseIrq  = 1'b1;
          stb.flagUndef = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          issueValid = 1'b1;
          stateNext  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (unitDone) begin
          stb.stepPc = 1'b1;
          stateNext  = ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: a word is handed to a unit for a single cycle only
  a_r2_issue_single: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);

  // R6: every job end returns the sequencer to idle
  a_r6_halt_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.raiseIrq |=> !busy);

  // R3: at most one program-counter action per cycle
  a_r3_single_pc_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadJob, stb.fetch, stb.stepPc, stb.branchPc, stb.raiseIrq}));

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStart,
  input  logic              hostAck,
  input  logic              jobActive,
  input  seqStrobe_t        stb,
  input  logic [PC_W-1:0]   progStart,
  input  logic [PC_W:0]     progLen,
  input  logic [OPC_W-1:0]  opc,
  input  logic [PC_W-1:0]   branchImm,
  input  logic [OPND_W-1:0] opA,
  output logic [PC_W-1:0]   pc,
  output logic              inWindow,
  output logic              irq,
  output logic              errUndef,
  output logic              errOverrun
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [PC_W-1:0] winStart;
  logic [PC_W:0]   winLen;
  logic [PC_W-1:0] winOffset;
  logic            taken;
  logic [PC_W-1:0] brOffset;
  logic [PC_W-1:0] branchTarget;

  assign winOffset = pc - winStart;
  assign inWindow  = ({1'b0, winOffset} < winLen);

  always_comb begin
    case (opc)
      OP_BRNZ32: taken = (opA[31:0] != 32'd0);
      OP_BRZ32:  taken = (opA[31:0] == 32'd0);
      OP_BRZ4:   taken = (opA[3:0] == 4'd0);
      OP_BRZ5:   taken = (opA[4:0] == 5'd0);
      default:   taken = 1'b0;
    endcase
  end

  assign brOffset     = taken ? (branchImm + PC_ONE) : PC_ONE;
  assign branchTarget = pc + brOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc         <= '0;
      winStart   <= '0;
      winLen     <= '0;
      irq        <= 1'b0;
      errUndef   <= 1'b0;
      errOverrun <= 1'b0;
    end else begin
      if (stb.loadJob) begin
        pc         <= progStart;
        winStart   <= progStart;
        winLen     <= progLen;
        errUndef   <= 1'b0;
        errOverrun <= 1'b0;
      end else if (stb.stepPc) begin
        pc <= pc + PC_ONE;
      end else if (stb.branchPc) begin
        pc <= branchTarget;
      end
      if (stb.raiseIrq)                   irq <= 1'b1;
      else if (stb.loadJob || hostAck)    irq <= 1'b0;
      if (stb.flagUndef)   errUndef   <= 1'b1;
      if (stb.flagOverrun) errOverrun <= 1'b1;
    end
  end

  // R8: the control never fetches a word outside the window
  a_r8_fetch_in_window: assert property (@(posedge clk) disable iff (!rstN)
    stb.fetch |-> inWindow);

  // R8: an overrun is always reported with the interrupt
  a_r8_overrun_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOverrun) |-> irq);

  // R9: interrupt holds until acknowledged or a new job starts
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !hostAck && !stb.loadJob) |=> irq);

  // R7: one job cannot end for two reasons
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(errUndef && errOverrun));

  // R10: a start during a job leaves the latched window untouched
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (jobActive && hostStart) |=> ($stable(winStart) && $stable(winLen)));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int INSTR_W  = 32,
  parameter int OPND_W   = 32,
  parameter int REG_AW   = 5,
  parameter int SRCA_LSB = 10,
  parameter int IMM_LSB  = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostStart,
  input  logic               hostAck,
  input  logic [PC_W-1:0]    progStart,
  input  logic [PC_W:0]      progLen,
  input  logic               ramWrEn,
  input  logic [PC_W-1:0]    ramWrAddr,
  input  logic [INSTR_W-1:0] ramWrData,
  input  logic [OPND_W-1:0]  opA,
  output logic [REG_AW-1:0]  regAddrA,
  output logic               issueValid,
  output logic [INSTR_W-1:0] issueInstr,
  input  logic               unitDone,
  output logic               busy,
  output logic               irq,
  output logic               errUndef,
  output logic               errOverrun
);

  seqStrobe_t        stb;
  logic [INSTR_W-1:0] curInstr;
  logic [PC_W-1:0]   pc;
  logic              inWindow;

  useq_ram #(.AW(PC_W), .DW(INSTR_W)) uRam (
    .clk   (clk),
    .we    (ramWrEn),
    .waddr (ramWrAddr),
    .wdata (ramWrData),
    .re    (stb.fetch),
    .raddr (pc),
    .rdata (curInstr)
  );

  useq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostStart  (hostStart),
    .unitDone   (unitDone),
    .inWindow   (inWindow),
    .opc        (curInstr[OPC_W-1:0]),
    .stb        (stb),
    .issueValid (issueValid),
    .busy       (busy)
  );

  useq_dpath #(.PC_W(PC_W), .OPND_W(OPND_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .hostStart  (hostStart),
    .hostAck    (hostAck),
    .jobActive  (busy),
    .stb        (stb),
    .progStart  (progStart),
    .progLen    (progLen),
    .opc        (curInstr[OPC_W-1:0]),
    .branchImm  (curInstr[IMM_LSB +: PC_W]),
    .opA        (opA),
    .pc         (pc),
    .inWindow   (inWindow),
    .irq        (irq),
    .errUndef   (errUndef),
    .errOverrun (errOverrun)
  );

  assign regAddrA   = curInstr[SRCA_LSB +: REG_AW];
  assign issueInstr = curInstr;

endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostStart, hostAck, ramWrEn, unitDone;
  logic [9:0]  progStart, ramWrAddr;
  logic [10:0] progLen;
  logic [31:0] ramWrData, opA, issueInstr;
  logic [4:0]  regAddrA;
  logic        issueValid, busy, irq, errUndef, errOverrun;

  always #5 clk = ~clk;

  useq_sequencer dut (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostAck(hostAck),
    .progStart(progStart), .progLen(progLen), .ramWrEn(ramWrEn),
    .ramWrAddr(ramWrAddr), .ramWrData(ramWrData), .opA(opA),
    .regAddrA(regAddrA), .issueValid(issueValid), .issueInstr(issueInstr),
    .unitDone(unitDone), .busy(busy), .irq(irq), .errUndef(errUndef),
    .errOverrun(errOverrun)
  );

  logic [31:0] regs [0:31];
  logic [31:0] mem  [0:1023];
  assign opA = regs[regAddrA];

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  int          obsCount;
  logic [31:0] obs [0:255];
  bit          slowDone = 0;
  int          expKind, expCount;
  logic [31:0] expTr [0:255];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int dst, input int ra,
                                     input int rb, input int imm);
    logic [31:0] w;
    w = '0;
    w[4:0]   = op[4:0];
    w[9:5]   = dst[4:0];
    w[14:10] = ra[4:0];
    w[19:15] = rb[4:0];
    w[29:20] = imm[9:0];
    return w;
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    ramWrEn = 1'b1; ramWrAddr = addr[9:0]; ramWrData = data;
    mem[addr & 1023] = data;
    @(negedge clk);
    ramWrEn = 1'b0;
  endtask

  // Reference interpreter built from R2..R8
  task automatic model(input int s, input int len);
    int pc, off, op, imm;
    logic [31:0] w, a;
    bit tk;
    pc = s; expCount = 0; expKind = -1;
    for (int step = 0; step < 400 && expKind < 0; step++) begin
      off = (pc - s) & 1023;
      if (off >= len) expKind = 2;
      else begin
        w = mem[pc]; op = int'(w[4:0]); imm = int'(w[29:20]); a = regs[w[14:10]];
        case (op)
          8:  tk = (a != 0);
          9:  tk = (a == 0);
          13: tk = (a[3:0] == 0);
          14: tk = (a[4:0] == 0);
          default: tk = 0;
        endcase
        if (op == 8 || op == 9 || op == 13 || op == 14) pc = (pc + (tk ? imm + 1 : 1)) & 1023;
        else if (op == 10) expKind = 0;
        else if (op >= 23) expKind = 1;
        else begin
          if (expCount < 256) expTr[expCount] = w;
          expCount++;
          pc = (pc + 1) & 1023;
        end
      end
    end
  endtask

  // Execution-unit responder
  initial begin
    unitDone = 1'b0;
    forever begin
      @(negedge clk);
      if (issueValid) begin
        if (obsCount < 256) obs[obsCount] = issueInstr;
        obsCount++;
        repeat (slowDone ? 12 : int'($urandom_range(1, 3))) @(negedge clk);
        unitDone = 1'b1;
        @(negedge clk);
        unitDone = 1'b0;
      end
    end
  end

  task automatic runJob(input int s, input int len, input bit poke);
    int bad;
    model(s, len);
    obsCount = 0;
    @(negedge clk);
    progStart = s[9:0]; progLen = len[10:0]; hostStart = 1'b1;
    @(negedge clk);
    hostStart = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(!irq && !errUndef && !errOverrun, "R9", "start clears irq/errors",
        {irq, errUndef, errOverrun}, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      progStart = 10'd0; progLen = 11'd5; hostStart = 1'b1;
      @(negedge clk);
      hostStart = 1'b0;
    end
    for (int t = 0; t < 4000 && !irq; t++) @(negedge clk);
    chk(irq == 1'b1, "R6", "irq at job end", irq, 1);
    chk(busy == 1'b0, "R6", "idle at job end", busy, 0);
    chk(errUndef == (expKind == 1), "R7", "undefined-opcode flag", errUndef, expKind == 1);
    chk(errOverrun == (expKind == 2), "R8", "overrun flag", errOverrun, expKind == 2);
    chk(obsCount == expCount, "R2", "issue count", obsCount, expCount);
    bad = 0;
    for (int i = 0; i < obsCount && i < expCount && i < 256; i++)
      if (obs[i] !== expTr[i]) bad++;
    chk(bad == 0, "R3", "issued word sequence (R4 R5)", bad, 0);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9", "irq held without ack", irq, 1);
    hostAck = 1'b1;
    @(negedge clk);
    hostAck = 1'b0;
    chk(irq == 1'b0, "R9", "irq cleared by ack", irq, 0);
    chk(errUndef == (expKind == 1) && errOverrun == (expKind == 2), "R9",
        "flags kept after ack", {errUndef, errOverrun}, {expKind == 1, expKind == 2});
  endtask

  localparam int NUNIT = 18;
  function automatic int unitOp(input int k);
    int tbl [NUNIT] = '{0, 1, 2, 3, 4, 5, 6, 7, 11, 12, 15, 16, 17, 18, 19, 20, 21, 22};
    return tbl[k];
  endfunction

  function automatic logic [31:0] rndWord();
    return $urandom();
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; hostStart = 1'b0; hostAck = 1'b0; ramWrEn = 1'b0;
    progStart = '0; progLen = '0; ramWrAddr = '0; ramWrData = '0;
    for (int i = 0; i < 32; i++) regs[i] = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    regs[1] = 32'h10;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !errUndef && !errOverrun && !issueValid, "R1", "outputs in reset",
        {busy, irq, errUndef, errOverrun, issueValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !errUndef && !errOverrun && !issueValid, "R1", "outputs after reset",
        {busy, irq, errUndef, errOverrun, issueValid}, 0);

    // R8: empty window
    runJob(300, 0, 0);
    chk(obsCount == 0, "R8", "no issue on zero length", obsCount, 0);

    // R3: backward wrap, r0 = 0, r1 = 0x10
    wr(5, mk(9, 0, 0, 0, 1));
    wr(6, mk(10, 0, 0, 0, 0));
    wr(7, mk(13, 0, 1, 0, 1022));
    runJob(5, 4, 0);
    chk(expKind == 0 && errUndef == 0 && errOverrun == 0, "R3", "backward branch reaches finish",
        {errUndef, errOverrun}, 0);

    // R4: flavours on operand 0x10
    wr(100, mk(14, 0, 1, 0, 3));
    wr(101, mk(13, 0, 1, 0, 1));
    wr(102, mk(25, 0, 0, 0, 0));
    wr(103, mk(8, 0, 1, 0, 0));
    wr(104, mk(3, 7, 2, 4, 9));
    wr(105, mk(10, 0, 0, 0, 0));
    runJob(100, 6, 0);
    chk(obsCount == 1 && obs[0] == mk(3, 7, 2, 4, 9), "R4", "only the unit word issued",
        obsCount, 1);

    // R8: window crossing address 1023
    wr(1022, mk(5, 1, 2, 3, 0));
    wr(1023, mk(6, 2, 3, 4, 0));
    wr(0, mk(9, 0, 0, 0, 5));
    runJob(1022, 4, 0);
    chk(errOverrun == 1'b1 && obsCount == 2, "R8", "overrun after wrap", obsCount, 2);

    // R7: undefined opcode
    wr(400, mk(16, 3, 3, 3, 0));
    wr(401, mk(23, 0, 0, 0, 0));
    runJob(400, 4, 0);
    chk(errUndef == 1'b1 && obsCount == 1, "R7", "halt on opcode 23", obsCount, 1);

    // R10: start during a job
    slowDone = 1;
    wr(500, mk(1, 1, 1, 1, 0));
    wr(501, mk(2, 2, 2, 2, 0));
    wr(502, mk(10, 0, 0, 0, 0));
    runJob(500, 3, 1);
    chk(obsCount == 2 && errOverrun == 1'b0, "R10", "second start ignored", obsCount, 2);
    slowDone = 0;

    // Random programs with forward branches
    for (int job = 0; job < 40; job++) begin
      int s, n, k;
      for (int i = 0; i < 32; i++) begin
        k = int'($urandom_range(0, 3));
        case (k)
          0: regs[i] = 32'd0;
          1: regs[i] = rndWord() & 32'hFFFF_FFE0;
          2: regs[i] = (rndWord() & 32'hFFFF_FFE0) | 32'h10;
          default: regs[i] = rndWord();
        endcase
      end
      s = int'($urandom_range(0, 1023));
      n = int'($urandom_range(1, 12));
      for (int i = 0; i < n; i++) begin
        logic [31:0] w;
        k = int'($urandom_range(0, 19));
        if (i == n - 1 && k < 13) w = mk(10, 0, 0, 0, 0);
        else if (k < 11) w = (rndWord() & 32'hFFFF_FFE0) | 32'(unitOp(int'($urandom_range(0, NUNIT - 1))));
        else if (k < 18) begin
          int bsel;
          bsel = int'($urandom_range(0, 3));
          w = mk(bsel == 0 ? 8 : bsel == 1 ? 9 : bsel == 2 ? 13 : 14, 0,
                 int'($urandom_range(0, 31)), 0, int'($urandom_range(0, 3)));
        end
        else if (k == 18) w = mk(int'($urandom_range(23, 31)), 0, 0, 0, 0);
        else w = mk(10, 0, 0, 0, 0);
        wr((s + i) & 1023, w);
      end
      runJob(s, n, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule